// File: doc/BRIEF.md
# MDIO Management Access Controller

This block is a register-driven master for the Ethernet PHY management interface. Software programs a 16-bit command register and a 16-bit data register through a simple write/read port. Setting the busy bit in the command register starts one management frame on MDC/MDIO. The busy bit reads back as 1 while the frame runs, so the same bit starts the transfer and is polled to see when it has finished.

A write frame sends the contents of the data register. A read frame releases MDIO for the turnaround and the data phase. It captures 16 bits from the PHY and places them in the data register when busy clears.

A clock-range field in the command register selects the divider that derives MDC from the system clock. Each command written by software must keep this field at its current value. The pad-level tri-state buffer sits outside the block and is driven from the output-enable pin.

Top module: `mdio_master`

## Requirements
- R1: The command register layout is as follows:
  - busy is bit 0;
  - write-select is bit 1 (1 = write frame, 0 = read frame);
  - clock range is bits [4:2];
  - bit 5 is spare storage;
  - PHY register address is bits [10:6];
  - PHY address is bits [15:11].

  A command write while idle stores bits [15:1], and they read back unchanged. Reset gives 0x0010 (clock range 4, all else 0). The data register reads back what was written and resets to 0.
- R2: A command write with bit 0 set while idle makes busy read 1 from the next cycle. Busy then stays 1 for exactly 64 MDC periods, that is 64 × divisor system clocks, and then clears by itself.
- R3: MDC has a period equal to the divisor chosen by the clock range, and is high for half of it. The divisors are:

  | Range code | Divisor |
  |---|---|
  | 0 | 42 |
  | 1 | 62 |
  | 2 | 16 |
  | 3 | 26 |
  | 4 | 102 |
  | 5 | 124 |
  | 6 | 102 |
  | 7 | 102 |
- R4: While no transfer runs, MDC is held low and MDIO is not driven (output enable 0).
- R5: A write frame drives all 64 bits, most significant first, in this order:
  - 32 ones;
  - start 01;
  - opcode 01;
  - the 5-bit PHY address;
  - the 5-bit register address;
  - turnaround 10;
  - the 16 data bits.

  Each bit changes only while MDC is low.
- R6: A read frame drives its first 46 bits: the preamble, start 01, opcode 10 and both addresses. It then releases MDIO for the 2 turnaround bits and the 16 data bits.
- R7: During a read, MDIO is sampled as MDC rises in each of the 16 data periods, most significant bit first. The 16-bit result is in the data register by the time busy reads 0.
- R8: A command write made while busy is 1 is ignored. The stored fields and the frame in progress are unchanged.
- R9: A command write with bit 0 clear only updates the stored fields and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_we | input | 1 | Write strobe for the command register |
| cmd_wdata | input | 16 | Command register write value |
| cmd_rdata | output | 16 | Command register read value, busy live in bit 0 |
| dat_we | input | 1 | Write strobe for the data register |
| dat_wdata | input | 16 | Data register write value |
| dat_rdata | output | 16 | Data register read value |
| mdc | output | 1 | Management clock to the PHY |
| mdio_o | output | 1 | MDIO value to drive |
| mdio_oe | output | 1 | MDIO output enable |
| mdio_i | input | 1 | MDIO value from the pad |

## Verification
Busy is due one cycle after the command write is sampled, and the bench reads it on the next falling clock edge. It then counts falling clock edges while busy reads 1 and expects exactly 64 times the divisor.

MDIO is sampled on the first falling clock edge after each MDC rise, which is half an MDC period from the next change of the line. The bench presents PHY read data right after the previous rise, so it is stable a full half period before the block samples it.

The data register and the idle levels of MDC and output enable are compared on the first sample at which busy reads 0.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
   // command register bit positions (software decodes these)
   localparam int POS_BUSY = 0;
   localparam int POS_WR   = 1;
   localparam int POS_RNG  = 2;
   localparam int RNG_W    = 3;
   localparam int POS_REG  = 6;
   localparam int POS_PHY  = 11;
   localparam int FLD_W    = 5;
   localparam int REG_W    = 16;
   localparam int MDIO_DW  = 16;
   localparam int MAX_DIV  = 124;

   // MDC divisor selected by the clock-range code
   function automatic int unsigned range_div(input logic [RNG_W-1:0] code);
      case (code)
         3'd0:    return 42;
         3'd1:    return 62;
         3'd2:    return 16;
         3'd3:    return 26;
         3'd5:    return 124;
         default: return 102;
      endcase
   endfunction
endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
   parameter int CNT_W = 7
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [CNT_W-1:0] div,
   output logic             mdc,
   output logic             rise_evt,
   output logic             fall_evt
);
   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] half;

   assign half     = div >> 1;
   assign rise_evt = run && (cnt == half - 1'b1);
   assign fall_evt = run && (cnt == div - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else if (!run || fall_evt) begin
         cnt <= '0;
         mdc <= 1'b0;
      end else begin
         cnt <= cnt + 1'b1;
         if (rise_evt) mdc <= 1'b1;
      end
   end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
   import mdio_pkg::*;
#(
   parameter int PRE_BITS = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               wr,
   input  logic [FLD_W-1:0]   phy,
   input  logic [FLD_W-1:0]   regad,
   input  logic [MDIO_DW-1:0] wdata,
   input  logic               rise_evt,
   input  logic               fall_evt,
   input  logic               mdio_i,
   output logic               busy,
   output logic               mdio_o,
   output logic               mdio_oe,
   output logic               rd_done,
   output logic [MDIO_DW-1:0] rdata
);
   localparam int HDR_BITS   = PRE_BITS + 4 + 2 * FLD_W;
   localparam int FRAME_BITS = HDR_BITS + 2 + MDIO_DW;
   localparam int IDX_W      = $clog2(FRAME_BITS);

   logic [FRAME_BITS-1:0] shreg;
   logic [IDX_W-1:0]      idx;
   logic                  wr_q;
   logic                  last;

   assign last    = (idx == IDX_W'(FRAME_BITS - 1));
   assign mdio_o  = shreg[FRAME_BITS-1];
   assign rd_done = busy && fall_evt && last && !wr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg   <= '0;
         idx     <= '0;
         busy    <= 1'b0;
         mdio_oe <= 1'b0;
         wr_q    <= 1'b0;
         rdata   <= '0;
      end else begin
         if (start && !busy) begin
            shreg   <= {{PRE_BITS{1'b1}}, 2'b01, (wr ? 2'b01 : 2'b10), phy, regad,
                        2'b10, (wr ? wdata : {MDIO_DW{1'b0}})};
            idx     <= '0;
            busy    <= 1'b1;
            mdio_oe <= 1'b1;
            wr_q    <= wr;
         end else if (busy && fall_evt) begin
            if (last) begin
               busy    <= 1'b0;
               mdio_oe <= 1'b0;
            end else begin
               idx     <= idx + 1'b1;
               shreg   <= shreg << 1;
               mdio_oe <= wr_q || ((int'(idx) + 1) < HDR_BITS);
            end
         end
         if (busy && rise_evt && !wr_q && (int'(idx) >= HDR_BITS + 2))
            rdata <= {rdata[MDIO_DW-2:0], mdio_i};
      end
   end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
   import mdio_pkg::*;
#(
   parameter int              PRE_BITS  = 32,
   parameter logic [RNG_W-1:0] RANGE_RST = 3'd4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cmd_we,
   input  logic [REG_W-1:0] cmd_wdata,
   output logic [REG_W-1:0] cmd_rdata,
   input  logic             dat_we,
   input  logic [REG_W-1:0] dat_wdata,
   output logic [REG_W-1:0] dat_rdata,
   output logic             mdc,
   output logic             mdio_o,
   output logic             mdio_oe,
   input  logic             mdio_i
);
   localparam int CNT_W = $clog2(MAX_DIV + 1);

   generate
      if (PRE_BITS < 1 || PRE_BITS > 32) begin : g_bad_pre
         $error("PRE_BITS must lie in 1..32");
      end
      if (REG_W != MDIO_DW) begin : g_bad_width
         $error("register width must equal the MDIO data width");
      end
   endgenerate

   logic [REG_W-1:1]   cmd_q;
   logic [REG_W-1:0]   dat_q;
   logic               busy;
   logic               start;
   logic               rise_evt;
   logic               fall_evt;
   logic               rd_done;
   logic [MDIO_DW-1:0] rcap;
   logic [CNT_W-1:0]   div_sel;

   assign start     = cmd_we && cmd_wdata[POS_BUSY] && !busy;
   assign div_sel   = CNT_W'(range_div(cmd_q[POS_RNG +: RNG_W]));
   assign cmd_rdata = {cmd_q, busy};
   assign dat_rdata = dat_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cmd_q                  <= '0;
         cmd_q[POS_RNG +: RNG_W] <= RANGE_RST;
      end else if (cmd_we && !busy) begin
         cmd_q <= cmd_wdata[REG_W-1:1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       dat_q <= '0;
      else if (rd_done) dat_q <= rcap;
      else if (dat_we)  dat_q <= dat_wdata;
   end

   mdio_clkgen #(.CNT_W(CNT_W)) u_clk (
      .clk      (clk),
      .rst_n    (rst_n),
      .run      (busy),
      .div      (div_sel),
      .mdc      (mdc),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt)
   );

   mdio_frame #(.PRE_BITS(PRE_BITS)) u_frame (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (start),
      .wr       (cmd_wdata[POS_WR]),
      .phy      (cmd_wdata[POS_PHY +: FLD_W]),
      .regad    (cmd_wdata[POS_REG +: FLD_W]),
      .wdata    (dat_q),
      .rise_evt (rise_evt),
      .fall_evt (fall_evt),
      .mdio_i   (mdio_i),
      .busy     (busy),
      .mdio_o   (mdio_o),
      .mdio_oe  (mdio_oe),
      .rd_done  (rd_done),
      .rdata    (rcap)
   );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk
   import mdio_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             cmd_we,
   input logic [REG_W-1:0] cmd_wdata,
   input logic [REG_W-1:0] cmd_rdata,
   input logic             mdc,
   input logic             mdio_o,
   input logic             mdio_oe
);
   logic [7:0] hi_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   hi_cnt <= '0;
      else if (mdc) hi_cnt <= hi_cnt + 1'b1;
      else          hi_cnt <= '0;
   end

   assert_idle_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !cmd_rdata[POS_BUSY] |-> (!mdc && !mdio_oe));

   assert_start_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_rdata[POS_BUSY]) |-> ($past(cmd_we) && $past(cmd_wdata[POS_BUSY])));

   assert_end_on_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmd_rdata[POS_BUSY]) |-> $fell(mdc));

   assert_high_half_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(mdc) |-> (int'(hi_cnt) == int'(range_div(cmd_rdata[POS_RNG +: RNG_W]) / 2)));

   assert_busy_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && cmd_rdata[POS_BUSY]) |=> $stable(cmd_rdata[REG_W-1:1]));

   assert_no_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_we && !cmd_wdata[POS_BUSY] && !cmd_rdata[POS_BUSY]) |=> !cmd_rdata[POS_BUSY]);

   assert_steady_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (mdc && $past(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));
endmodule

bind mdio_master mdio_master_chk u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cmd_we    (cmd_we),
   .cmd_wdata (cmd_wdata),
   .cmd_rdata (cmd_rdata),
   .mdc       (mdc),
   .mdio_o    (mdio_o),
   .mdio_oe   (mdio_oe)
);

// File: tb/tb_mdio_master.sv
module tb_mdio_master;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_we = 1'b0;
   logic [15:0] cmd_wdata = '0;
   logic [15:0] cmd_rdata;
   logic        dat_we = 1'b0;
   logic [15:0] dat_wdata = '0;
   logic [15:0] dat_rdata;
   logic        mdc, mdio_o, mdio_oe;
   logic        mdio_i = 1'b1;
   int          total = 0;
   int          bad = 0;
   bit          finished = 0;

   always #10 clk = ~clk;

   mdio_master dut (
      .clk(clk), .rst_n(rst_n), .cmd_we(cmd_we), .cmd_wdata(cmd_wdata),
      .cmd_rdata(cmd_rdata), .dat_we(dat_we), .dat_wdata(dat_wdata),
      .dat_rdata(dat_rdata), .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe),
      .mdio_i(mdio_i)
   );

   task automatic check(input bit ok, input string req, input string what,
                        input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_div(input logic [2:0] c);
      case (c)
         3'd0: return 42;
         3'd1: return 62;
         3'd2: return 16;
         3'd3: return 26;
         3'd5: return 124;
         default: return 102;
      endcase
   endfunction

   function automatic logic [63:0] exp_frame(input bit wr, input logic [4:0] p,
                                             input logic [4:0] r, input logic [15:0] d);
      return {32'hFFFF_FFFF, 2'b01, (wr ? 2'b01 : 2'b10), p, r, 2'b10, (wr ? d : 16'h0)};
   endfunction

   task automatic run_frame(input bit wr, input logic [4:0] p, input logic [4:0] r,
                            input logic [2:0] rng, input logic [15:0] wd,
                            input logic [15:0] pv, input bit inject);
      logic [63:0] ef;
      logic [15:0] cmdv;
      int idx, busycnt, last_rise, dv;
      bit prev_mdc, bits_ok, oe_ok, per_ok, exp_oe;
      ef = exp_frame(wr, p, r, wd);
      dv = exp_div(rng);
      cmdv = {p, r, 1'b0, rng, wr, 1'b1};
      if (wr) begin
         @(negedge clk); dat_we = 1'b1; dat_wdata = wd;
         @(negedge clk); dat_we = 1'b0;
      end
      @(negedge clk); cmd_we = 1'b1; cmd_wdata = cmdv; mdio_i = 1'b1;
      @(negedge clk); cmd_we = 1'b0;
      check(cmd_rdata[0] == 1'b1, "R2", "busy after start", 64'(cmd_rdata[0]), 64'd1);
      idx = 0; busycnt = 0; last_rise = -1; prev_mdc = 1'b0;
      bits_ok = 1'b1; oe_ok = 1'b1; per_ok = 1'b1;
      while (cmd_rdata[0] && busycnt < 20000) begin
         busycnt++;
         if (cmd_we) cmd_we = 1'b0;
         if (mdc && !prev_mdc) begin
            if (idx < 64) begin
               exp_oe = wr || (idx < 46);
               if (mdio_oe != exp_oe) oe_ok = 1'b0;
               if (exp_oe && mdio_o != ef[63-idx]) bits_ok = 1'b0;
            end
            if (last_rise >= 0 && (busycnt - last_rise) != dv) per_ok = 1'b0;
            last_rise = busycnt;
            idx++;
            mdio_i = (idx >= 48 && idx < 64) ? pv[63-idx] : 1'b1;
            if (inject && idx == 10) begin
               cmd_we = 1'b1; cmd_wdata = cmdv ^ 16'hFFFE;
            end
         end
         prev_mdc = mdc;
         @(negedge clk);
      end
      mdio_i = 1'b1;
      check(busycnt == 64 * dv, "R2", "busy cycles", 64'(busycnt), 64'(64 * dv));
      check(idx == 64, "R2", "MDC periods", 64'(idx), 64'd64);
      check(per_ok, "R3", "MDC period", 64'(per_ok), 64'(dv));
      check(!mdc && !mdio_oe, "R4", "idle after frame", {mdc, mdio_oe}, 64'd0);
      if (wr) begin
         check(bits_ok, "R5", "write frame bits", ef, ef);
         check(oe_ok, "R5", "write frame drive", 64'(oe_ok), 64'd1);
      end else begin
         check(bits_ok, "R6", "read header bits", ef, ef);
         check(oe_ok, "R6", "read release pattern", 64'(oe_ok), 64'd1);
         check(dat_rdata == pv, "R7", "read data", 64'(dat_rdata), 64'(pv));
      end
      if (inject)
         check(cmd_rdata == (cmdv & 16'hFFFE), "R8", "command while busy",
               64'(cmd_rdata), 64'(cmdv & 16'hFFFE));
      else
         check(cmd_rdata == (cmdv & 16'hFFFE), "R1", "fields after frame",
               64'(cmd_rdata), 64'(cmdv & 16'hFFFE));
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         total++; bad++;
         $display("FAIL watchdog: actual=running expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      bit quiet;
      seed = $urandom(32'h1F2E);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check(cmd_rdata == 16'h0010, "R1", "reset command", 64'(cmd_rdata), 64'h10);
      check(dat_rdata == 16'h0, "R1", "reset data", 64'(dat_rdata), 64'h0);
      check(!mdc && !mdio_oe, "R4", "reset idle", {mdc, mdio_oe}, 64'd0);

      // R9: fields only, busy bit clear
      cmd_we = 1'b1; cmd_wdata = {5'h15, 5'h0A, 1'b1, 3'd2, 1'b1, 1'b0};
      @(negedge clk); cmd_we = 1'b0;
      quiet = 1'b1;
      repeat (40) begin
         if (cmd_rdata[0] || mdc || mdio_oe) quiet = 1'b0;
         @(negedge clk);
      end
      check(quiet, "R9", "no frame without busy bit", 64'(quiet), 64'd1);
      check(cmd_rdata == {5'h15, 5'h0A, 1'b1, 3'd2, 1'b1, 1'b0}, "R1", "field readback",
            64'(cmd_rdata), 64'({5'h15, 5'h0A, 1'b1, 3'd2, 1'b1, 1'b0}));
      dat_we = 1'b1; dat_wdata = 16'h3C5A;
      @(negedge clk); dat_we = 1'b0;
      check(dat_rdata == 16'h3C5A, "R1", "data readback", 64'(dat_rdata), 64'h3C5A);

      for (int i = 0; i < 4; i++)
         run_frame(1'b1, 5'($urandom), 5'($urandom), 3'd2, 16'($urandom), 16'h0, 1'b0);
      for (int i = 0; i < 4; i++)
         run_frame(1'b0, 5'($urandom), 5'($urandom), 3'($urandom_range(3, 2)),
                   16'h0, 16'($urandom), 1'b0);
      run_frame(1'b1, 5'h00, 5'h00, 3'd0, 16'h0000, 16'h0, 1'b0);
      run_frame(1'b0, 5'h1F, 5'h1F, 3'd4, 16'h0, 16'hFFFF, 1'b0);
      run_frame(1'b0, 5'h01, 5'h10, 3'd2, 16'h0, 16'h8001, 1'b1);
      run_frame(1'b1, 5'h1F, 5'h01, 3'd5, 16'hA5A5, 16'h0, 1'b1);

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule